// File: doc/BRIEF.md
# CAN Controller Configuration Guard

This block stands between a byte-wide CPU register port and the configuration state of a CAN protocol controller. It keeps the settings that must not move while the controller is on the bus in a guarded register file. These are the two bit-timing bytes, the filter-control byte, eight filter-code bytes, eight filter-mask bytes and the protocol clock-source choice. A write to any of them lands only while initialization mode is acknowledged. At all other times the write is dropped without an error.

Software asks for initialization by setting a request bit. The block answers with an acknowledge bit after a short synchronisation delay, counted in protocol-clock cycles. The receive and transmit error counters are loaded only by the protocol engine and cannot be changed by the CPU. The module-enable bit accepts a single write after reset. The transmit pin is held recessive while initialization is requested or acknowledged, and while power-down is requested. The block also chooses the protocol clock, which is either every system clock or an oscillator enable pulse. It divides that clock by a programmable 1 to 64 to make the time-quantum tick for the bit engine.

Top module: `can_cfg_guard`

## Requirements
- R1: After reset the initialization request (CTL0 bit 0) reads 1, the acknowledge `init_ack` is 1, `mod_enable` is 0, both error counters read 0 and `can_tx` is 1.
- R2: `init_ack` follows the request bit two protocol-clock cycles later. It rises two cycles after the request is set and falls two cycles after the request is cleared.
- R3: Writes to TIM0 (address 2), TIM1 (3), filter control (4), filter codes (8 to 15), filter masks (16 to 23) and the clock-select bit (CTL1 bit 6) take effect only while `init_ack` is 1. Otherwise the stored value does not change.
- R4: The receive counter (address 5) and the transmit counter (address 6) change only on `err_load`. Bus writes to them have no effect.
- R5: The enable bit (CTL1 bit 7) takes the value of the first write to CTL1 after reset. Later writes leave it unchanged.
- R6: `can_tx` is 1 whenever the request bit, `init_ack` or the power-down bit (CTL0 bit 1) is 1. Otherwise it equals `eng_tx`.
- R7: With CTL1 bit 6 at 1, the protocol clock advances on every system clock. With that bit at 0, it advances only on cycles where `osc_en` is 1.
- R8: While `init_ack` is 0, `tq_tick` pulses once every N protocol-clock cycles, where N = TIM0[5:0] + 1. While `init_ack` is 1 it stays 0.
- R9: The first `tq_tick` after `init_ack` falls comes in the Nth protocol-clock cycle, counting the first cycle with `init_ack` at 0 as cycle 1.
- R10: `rd_data` returns the register at `rd_addr` in the same cycle. CTL0 reads {6'b0, power-down, request}, CTL1 reads {enable, clock-select, 5'b0, `init_ack`}, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator clock enable pulse |
| wr_en | input | 1 | One-cycle write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Read data, combinational |
| err_load | input | 1 | Engine strobe that loads both error counters |
| rx_err_new | input | 8 | New receive error count |
| tx_err_new | input | 8 | New transmit error count |
| eng_tx | input | 1 | Transmit bit from the protocol engine |
| can_tx | output | 1 | Transmit pin, 1 is recessive |
| tq_tick | output | 1 | Time-quantum tick |
| init_ack | output | 1 | Initialization acknowledged, configuration unlocked |
| mod_enable | output | 1 | Module enable |
| bus_timing | output | 16 | {TIM1, TIM0} |
| filt_ctrl | output | 8 | Filter control byte |
| filt_code | output | 64 | Filter codes, byte i at bits 8i+7:8i |
| filt_mask | output | 64 | Filter masks, byte i at bits 8i+7:8i |

## Verification
A wrong lock state shows up in the read-back of the first guarded byte written after the wrong transition. It also moves `bus_timing` and `filt_code` one cycle after the offending strobe. A handshake pipeline that is off by a stage moves the `init_ack` edge by one cycle. That edge is sampled in the exact cycle the requirement gives, and a stray pipeline stage also moves the first tick. A bad prescaler reload or count appears in the first tick after leaving initialization and in each later tick interval. With the oscillator clock, a wrong clock choice shows as a tick count over a fixed window that is off by a factor of three.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int N_FILT  = 8;
    localparam int FIDX_W  = $clog2(N_FILT);

    localparam logic [ADDR_W-1:0] A_CTL0 = 5'd0;
    localparam logic [ADDR_W-1:0] A_CTL1 = 5'd1;
    localparam logic [ADDR_W-1:0] A_TIM0 = 5'd2;
    localparam logic [ADDR_W-1:0] A_TIM1 = 5'd3;
    localparam logic [ADDR_W-1:0] A_FCTL = 5'd4;
    localparam logic [ADDR_W-1:0] A_RXE  = 5'd5;
    localparam logic [ADDR_W-1:0] A_TXE  = 5'd6;
    // upper address bits selecting the filter code / mask windows
    localparam logic [ADDR_W-FIDX_W-1:0] CODE_WIN = 2'b01;
    localparam logic [ADDR_W-FIDX_W-1:0] MASK_WIN = 2'b10;
endpackage

// File: rtl/cfgp_handshake.sv
module cfgp_handshake #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pclk_en,
    input  logic req,
    output logic ack
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } hs_t;

    hs_t hs_d, hs_q;

    always_comb begin
        hs_d = hs_q;
        if (pclk_en) begin
            hs_d.pipe = {hs_q.pipe[STAGES-2:0], req};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q.pipe <= '1;
        else        hs_q <= hs_d;
    end

    assign ack = hs_q.pipe[STAGES-1];
endmodule

// File: rtl/cfgp_prescaler.sv
module cfgp_prescaler #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pclk_en,
    input  logic         hold,
    input  logic [W-1:0] div_m1,
    output logic         tick
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } ps_t;

    ps_t ps_d, ps_q;

    always_comb begin
        ps_d = ps_q;
        if (hold) begin
            ps_d.cnt = div_m1;
        end else if (pclk_en) begin
            ps_d.cnt = (ps_q.cnt == '0) ? div_m1 : ps_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '0;
        else        ps_q <= ps_d;
    end

    assign tick = pclk_en && !hold && (ps_q.cnt == '0);
endmodule

// File: rtl/cfgp_regs.sv
module cfgp_regs
    import cfgp_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         unlocked,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [ADDR_W-1:0]            rd_addr,
    output logic [DATA_W-1:0]            rd_data,
    input  logic                         err_load,
    input  logic [DATA_W-1:0]            rx_err_new,
    input  logic [DATA_W-1:0]            tx_err_new,
    output logic                         req,
    output logic                         sleep,
    output logic                         enable,
    output logic                         csel,
    output logic [DATA_W-1:0]            tim0,
    output logic [DATA_W-1:0]            tim1,
    output logic [DATA_W-1:0]            fctl,
    output logic [DATA_W-1:0]            rx_err,
    output logic [DATA_W-1:0]            tx_err,
    output logic [N_FILT-1:0][DATA_W-1:0] code,
    output logic [N_FILT-1:0][DATA_W-1:0] mask
);
    typedef struct packed {
        logic                          req;
        logic                          sleep;
        logic                          en;
        logic                          en_done;
        logic                          csel;
        logic [DATA_W-1:0]             tim0;
        logic [DATA_W-1:0]             tim1;
        logic [DATA_W-1:0]             fctl;
        logic [DATA_W-1:0]             rxe;
        logic [DATA_W-1:0]             txe;
        logic [N_FILT-1:0][DATA_W-1:0] code;
        logic [N_FILT-1:0][DATA_W-1:0] mask;
    } rf_t;

    rf_t rf_d, rf_q;

    logic [ADDR_W-FIDX_W-1:0] win;
    logic [FIDX_W-1:0]        widx;
    logic [FIDX_W-1:0]        ridx;
    assign win  = wr_addr[ADDR_W-1:FIDX_W];
    assign widx = wr_addr[FIDX_W-1:0];
    assign ridx = rd_addr[FIDX_W-1:0];

    always_comb begin
        rf_d = rf_q;
        if (wr_en) begin
            case (wr_addr)
                A_CTL0: begin
                    rf_d.req   = wr_data[0];
                    rf_d.sleep = wr_data[1];
                end
                A_CTL1: begin
                    if (!rf_q.en_done) begin
                        rf_d.en      = wr_data[7];
                        rf_d.en_done = 1'b1;
                    end
                    if (unlocked) rf_d.csel = wr_data[6];
                end
                A_TIM0: if (unlocked) rf_d.tim0 = wr_data;
                A_TIM1: if (unlocked) rf_d.tim1 = wr_data;
                A_FCTL: if (unlocked) rf_d.fctl = wr_data;
                default: begin
                    if (unlocked && win == CODE_WIN) rf_d.code[widx] = wr_data;
                    if (unlocked && win == MASK_WIN) rf_d.mask[widx] = wr_data;
                end
            endcase
        end
        if (err_load) begin
            rf_d.rxe = rx_err_new;
            rf_d.txe = tx_err_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q     <= '0;
            rf_q.req <= 1'b1;
        end else begin
            rf_q <= rf_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTL0: rd_data = {6'b0, rf_q.sleep, rf_q.req};
            A_CTL1: rd_data = {rf_q.en, rf_q.csel, 5'b0, unlocked};
            A_TIM0: rd_data = rf_q.tim0;
            A_TIM1: rd_data = rf_q.tim1;
            A_FCTL: rd_data = rf_q.fctl;
            A_RXE:  rd_data = rf_q.rxe;
            A_TXE:  rd_data = rf_q.txe;
            default: begin
                if (rd_addr[ADDR_W-1:FIDX_W] == CODE_WIN) rd_data = rf_q.code[ridx];
                if (rd_addr[ADDR_W-1:FIDX_W] == MASK_WIN) rd_data = rf_q.mask[ridx];
            end
        endcase
    end

    assign req    = rf_q.req;
    assign sleep  = rf_q.sleep;
    assign enable = rf_q.en;
    assign csel   = rf_q.csel;
    assign tim0   = rf_q.tim0;
    assign tim1   = rf_q.tim1;
    assign fctl   = rf_q.fctl;
    assign rx_err = rf_q.rxe;
    assign tx_err = rf_q.txe;
    assign code   = rf_q.code;
    assign mask   = rf_q.mask;
endmodule

// File: rtl/can_cfg_guard.sv
module can_cfg_guard
    import cfgp_pkg::*;
#(
    parameter int HS_STAGES = 2,
    parameter int PRE_W     = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       osc_en,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    input  logic                       err_load,
    input  logic [DATA_W-1:0]          rx_err_new,
    input  logic [DATA_W-1:0]          tx_err_new,
    input  logic                       eng_tx,
    output logic                       can_tx,
    output logic                       tq_tick,
    output logic                       init_ack,
    output logic                       mod_enable,
    output logic [2*DATA_W-1:0]        bus_timing,
    output logic [DATA_W-1:0]          filt_ctrl,
    output logic [N_FILT*DATA_W-1:0]   filt_code,
    output logic [N_FILT*DATA_W-1:0]   filt_mask
);
    logic                          req_w, sleep_w, csel_w, pclk_en;
    logic [DATA_W-1:0]             tim0_w, tim1_w, rxe_w, txe_w;
    logic [N_FILT-1:0][DATA_W-1:0] code_w, mask_w;

    cfgp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .unlocked(init_ack),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .err_load(err_load), .rx_err_new(rx_err_new), .tx_err_new(tx_err_new),
        .req(req_w), .sleep(sleep_w), .enable(mod_enable), .csel(csel_w),
        .tim0(tim0_w), .tim1(tim1_w), .fctl(filt_ctrl),
        .rx_err(rxe_w), .tx_err(txe_w), .code(code_w), .mask(mask_w)
    );

    assign pclk_en = csel_w ? 1'b1 : osc_en;

    cfgp_handshake #(.STAGES(HS_STAGES)) u_hs (
        .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .req(req_w), .ack(init_ack)
    );

    cfgp_prescaler #(.W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .hold(init_ack),
        .div_m1(tim0_w[PRE_W-1:0]), .tick(tq_tick)
    );

    assign can_tx     = (req_w || init_ack || sleep_w) ? 1'b1 : eng_tx;
    assign bus_timing = {tim1_w, tim0_w};
    assign filt_code  = code_w;
    assign filt_mask  = mask_w;
endmodule

module cfgp_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [4:0]  wr_addr,
    input logic        init_req,
    input logic        init_ack,
    input logic        tq_tick,
    input logic        can_tx,
    input logic        mod_enable,
    input logic        err_load,
    input logic [7:0]  rx_err,
    input logic [15:0] bus_timing
);
    // R3
    locked_tim1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !init_ack && wr_addr == 5'd3) |=> $stable(bus_timing[15:8]));
    // R5
    enable_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mod_enable |=> mod_enable);
    // R2
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_ack) |-> $past(init_req, 2));
    // R6
    tx_recessive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_ack |-> can_tx);
    // R8
    no_tick_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_ack |-> !tq_tick);
    // R4
    rx_err_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 5'd5 && !err_load) |=> $stable(rx_err));
endmodule

bind can_cfg_guard cfgp_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .init_req(req_w), .init_ack(init_ack), .tq_tick(tq_tick), .can_tx(can_tx),
    .mod_enable(mod_enable), .err_load(err_load), .rx_err(rxe_w),
    .bus_timing(bus_timing)
);

// File: tb/can_cfg_guard_test.sv
module can_cfg_guard_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        err_load = 1'b0;
    logic [7:0]  rx_err_new = '0, tx_err_new = '0;
    logic        eng_tx = 1'b0;
    logic        can_tx, tq_tick, init_ack, mod_enable;
    logic [15:0] bus_timing;
    logic [7:0]  filt_ctrl;
    logic [63:0] filt_code, filt_mask;

    int checks = 0, fails = 0;
    int cycles = 0;
    bit osc_run = 1'b0;
    int osc_ph = 0;
    logic [7:0] exp_reg [0:23];

    can_cfg_guard uut (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .err_load(err_load),
        .rx_err_new(rx_err_new), .tx_err_new(tx_err_new), .eng_tx(eng_tx),
        .can_tx(can_tx), .tq_tick(tq_tick), .init_ack(init_ack), .mod_enable(mod_enable),
        .bus_timing(bus_timing), .filt_ctrl(filt_ctrl), .filt_code(filt_code),
        .filt_mask(filt_mask)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (osc_run) begin
            osc_en <= (osc_ph == 0);
            osc_ph <= (osc_ph + 1) % 3;
        end else begin
            osc_en <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    function automatic logic [4:0] prot_addr(input int k);
        if (k < 3)  return 5'(k + 2);
        if (k < 11) return 5'(k - 3 + 8);
        return 5'(k - 11 + 16);
    endfunction

    task automatic random_writes(input bit unlocked_now, input int n);
        for (int i = 0; i < n; i++) begin
            logic [4:0] a;
            logic [7:0] d;
            a = prot_addr($urandom % 19);
            d = 8'($urandom);
            wr(a, d);
            if (unlocked_now) exp_reg[a] = d;
        end
    endtask

    task automatic check_all(input string req);
        logic [7:0] v;
        for (int k = 0; k < 19; k++) begin
            logic [4:0] a;
            a = prot_addr(k);
            rd(a, v);
            chk(req, v, exp_reg[a]);
        end
        chk(req, bus_timing, {exp_reg[3], exp_reg[2]});
        chk(req, filt_code[15:8], exp_reg[9]);
        chk(req, filt_mask[63:56], exp_reg[23]);
    endtask

    initial begin
        logic [7:0] v;
        int n_tick;
        int first;
        void'($urandom(32'd1234));
        for (int i = 0; i < 24; i++) exp_reg[i] = 8'h00;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ack", init_ack, 1);
        chk("R1 enable", mod_enable, 0);
        chk("R1 tx", can_tx, 1);
        rd(5'd0, v); chk("R1/R10 ctl0", v, 8'h01);
        rd(5'd1, v); chk("R1/R10 ctl1", v, 8'h01);
        rd(5'd5, v); chk("R1 rx err", v, 8'h00);
        rd(5'd6, v); chk("R1 tx err", v, 8'h00);
        rd(5'd7, v); chk("R10 unmapped", v, 8'h00);

        // R5 write-once enable, clock select while unlocked (R3)
        wr(5'd1, 8'hC0);
        chk("R5 enable set", mod_enable, 1);
        rd(5'd1, v); chk("R10 ctl1", v, 8'hC1);
        wr(5'd1, 8'h00);
        chk("R5 enable kept", mod_enable, 1);
        rd(5'd1, v); chk("R3 csel unlocked", v, 8'h81);
        wr(5'd1, 8'h40);
        rd(5'd1, v); chk("R3 csel unlocked", v, 8'hC1);

        // R3 unlocked random writes
        random_writes(1'b1, 40);
        wr(5'd2, 8'h04); exp_reg[2] = 8'h04;    // N = 5
        check_all("R3 unlocked write");

        // R2 / R9 leave initialization on bus clock
        wr(5'd0, 8'h00);
        chk("R2 ack hold 0", init_ack, 1);
        @(negedge clk); chk("R2 ack hold 1", init_ack, 1);
        @(negedge clk); chk("R2 ack fall", init_ack, 0);
        first = 0;
        for (int i = 1; i <= 70; i++) begin
            if (tq_tick && first == 0) first = i;
            if (first == 0) @(negedge clk);
        end
        chk("R9 first tick", first, 5);
        // R8 interval
        @(negedge clk);
        n_tick = 0;
        for (int i = 0; i < 50; i++) begin
            if (tq_tick) n_tick++;
            @(negedge clk);
        end
        chk("R8 tick count", n_tick, 10);

        // R6 online tx follows engine
        eng_tx = 1'b0; #1 chk("R6 tx follow 0", can_tx, 0);
        eng_tx = 1'b1; #1 chk("R6 tx follow 1", can_tx, 1);
        eng_tx = 1'b0;

        // R3 locked writes ignored
        random_writes(1'b0, 40);
        check_all("R3 locked write");
        wr(5'd1, 8'h00);
        rd(5'd1, v); chk("R3/R5 ctl1 locked", v, 8'hC0);

        // R4 error counters
        @(negedge clk);
        err_load = 1'b1; rx_err_new = 8'h21; tx_err_new = 8'h7F;
        @(negedge clk);
        err_load = 1'b0;
        rd(5'd5, v); chk("R4 rx load", v, 8'h21);
        rd(5'd6, v); chk("R4 tx load", v, 8'h7F);
        wr(5'd5, 8'hAA); wr(5'd6, 8'h55);
        rd(5'd5, v); chk("R4 rx ro", v, 8'h21);
        rd(5'd6, v); chk("R4 tx ro", v, 8'h7F);

        // R6 power-down forces recessive
        wr(5'd0, 8'h02);
        chk("R6 sleep tx", can_tx, 1);
        chk("R6 sleep no init", init_ack, 0);
        wr(5'd0, 8'h00);
        chk("R6 wake tx", can_tx, 0);

        // R6 / R2 re-enter initialization
        wr(5'd0, 8'h01);
        chk("R6 req tx", can_tx, 1);
        chk("R2 ack not yet", init_ack, 0);
        @(negedge clk); chk("R2 ack not yet 1", init_ack, 0);
        @(negedge clk); chk("R2 ack rise", init_ack, 1);
        chk("R8 no tick in init", tq_tick, 0);

        // R7 oscillator clock: N = 2, pulse every 3 cycles
        wr(5'd1, 8'h00);
        wr(5'd2, 8'h01); exp_reg[2] = 8'h01;
        rd(5'd1, v); chk("R7 csel cleared", v, 8'h81);
        osc_run = 1'b1;
        wr(5'd0, 8'h00);
        for (int i = 0; i < 40 && init_ack; i++) @(negedge clk);
        chk("R7 ack fell on osc", init_ack, 0);
        repeat (10) @(negedge clk);
        n_tick = 0;
        for (int i = 0; i < 60; i++) begin
            if (tq_tick) n_tick++;
            @(negedge clk);
        end
        chk("R7 osc tick count", n_tick, 10);
        osc_run = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule